// File: doc/BRIEF.md
# Two-Phase Shift-Add Multiplier

This block multiplies two unsigned operands by repeated addition and shifting, with no multiply operator anywhere in the datapath. A load strobe captures both operands. The wide multiplicand register takes the first operand, zero-extended. The narrow multiplier register takes the second operand. The product register is cleared.

After the load, a one-bit phase register alternates between an add cycle and a shift cycle. In an add cycle, the multiplicand register is added into the product register when the multiplier's least significant bit is set. In a shift cycle, the multiplicand moves one place left and the multiplier moves one place right.

The loop has no iteration limit and no terminal state. It runs freely. Once the multiplier register holds only zeros, the product register stops changing and holds the full-width unsigned product. The block flags that condition on `done`. A new load may arrive at any time and restarts the operation.

Top module: `shadd_mul`

## Requirements
- R1: After a synchronous active-high reset, `product` reads 0 and `done` reads 1.
- R2: On the clock edge where `loadIn` is high, the product register is cleared, the multiplicand register takes `aIn` zero-extended to 32 bits, and the multiplier register takes `bIn`. The edge that follows is an add cycle.
- R3: In an add cycle, when multiplier bit 0 is 1, `product` becomes its previous value plus the multiplicand register. When that bit is 0, `product` keeps its value.
- R4: In a shift cycle, `product` keeps its value. The multiplicand register shifts left by one and the multiplier register shifts right by one, each filling with a zero.
- R5: Add cycles and shift cycles alternate strictly, one per clock, for as long as no load arrives.
- R6: `done` is 1 exactly when the multiplier register is all zeros. While `done` is 1 and no load arrives, `product` does not change.
- R7: When `done` is 1 after a load, `product` equals the unsigned product of the loaded `aIn` and `bIn`. This holds for corner operands 0, 1 and 0xFFFF.
- R8: A load that arrives in the middle of an operation takes precedence over the add or shift step of that cycle. The result is then that of the new operands.
- R9: `done` rises no later than 32 clock cycles after the load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadIn | input | 1 | Load strobe that captures both operands |
| aIn | input | 16 | Multiplicand operand |
| bIn | input | 16 | Multiplier operand |
| product | output | 32 | Product register |
| done | output | 1 | High when no multiplier bits remain |

## Verification
A load strobe can coincide with either an add cycle or a shift cycle of an operation already in flight. In that cycle the load must win, and the pending step must not touch the freshly cleared registers.

The bench starts a long operation with a full-ones multiplier. It asserts a second load exactly on the clock edge that would otherwise have been a shift cycle.

The bench judges the outcome in two steps. It first checks that `product` reads zero right after that edge. It then checks that the settled result equals the second operand pair's product and not a mixture of both operations.

// File: rtl/shadd_mul_pkg.sv
package shadd_mul_pkg;
  typedef struct packed {
    logic loadOps;
    logic addStep;
    logic shiftStep;
  } stepCtrl_t;
endpackage

// File: rtl/shadd_mul_ctrl.sv
module shadd_mul_ctrl
  import shadd_mul_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      loadIn,
  output stepCtrl_t strobes,
  output logic      phase
);
  // phase 0 = add cycle, phase 1 = shift cycle
  always_ff @(posedge clk) begin
    if (rst)         phase <= 1'b0;
    else if (loadIn) phase <= 1'b0;
    else             phase <= ~phase;
  end

  always_comb begin
    strobes.loadOps   = loadIn;
    strobes.addStep   = !loadIn && !phase;
    strobes.shiftStep = !loadIn && phase;
  end
endmodule

// File: rtl/shadd_mul_dp.sv
module shadd_mul_dp
  import shadd_mul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  stepCtrl_t         strobes,
  input  logic [OP_W-1:0]   aIn,
  input  logic [OP_W-1:0]   bIn,
  output logic [2*OP_W-1:0] prodQ,
  output logic [2*OP_W-1:0] mcandQ,
  output logic [OP_W-1:0]   mplierQ,
  output logic              mplierEmpty
);
  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] addend;
  logic [PROD_W-1:0] sum;
  logic              takeBit;

  assign takeBit = strobes.addStep && mplierQ[0];

  // gate the multiplicand into the adder bit by bit
  for (genvar i = 0; i < PROD_W; i++) begin : g_gate
    assign addend[i] = mcandQ[i] & takeBit;
  end

  assign sum         = prodQ + addend;
  assign mplierEmpty = (mplierQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prodQ   <= '0;
      mcandQ  <= '0;
      mplierQ <= '0;
    end else if (strobes.loadOps) begin
      prodQ   <= '0;
      mcandQ  <= {{(PROD_W-OP_W){1'b0}}, aIn};
      mplierQ <= bIn;
    end else if (strobes.shiftStep) begin
      mcandQ  <= {mcandQ[PROD_W-2:0], 1'b0};
      mplierQ <= {1'b0, mplierQ[OP_W-1:1]};
    end else begin
      prodQ   <= sum;
    end
  end
endmodule

// File: rtl/shadd_mul.sv
module shadd_mul
  import shadd_mul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadIn,
  input  logic [OP_W-1:0]   aIn,
  input  logic [OP_W-1:0]   bIn,
  output logic [2*OP_W-1:0] product,
  output logic              done
);
  stepCtrl_t         strobes;
  logic              phaseNow;
  logic [2*OP_W-1:0] mcandNow;
  logic [OP_W-1:0]   mplierNow;

  shadd_mul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .loadIn(loadIn),
    .strobes(strobes), .phase(phaseNow)
  );

  shadd_mul_dp #(.OP_W(OP_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .aIn(aIn), .bIn(bIn),
    .prodQ(product), .mcandQ(mcandNow), .mplierQ(mplierNow),
    .mplierEmpty(done)
  );
endmodule

// File: rtl/shadd_mul_chk.sv
module shadd_mul_chk #(
  parameter int OP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              loadIn,
  input logic [OP_W-1:0]   aIn,
  input logic [OP_W-1:0]   bIn,
  input logic [2*OP_W-1:0] product,
  input logic              done,
  input logic              phaseNow,
  input logic [2*OP_W-1:0] mcandNow,
  input logic [OP_W-1:0]   mplierNow
);
  p_load_clear_r2: assert property (@(posedge clk) disable iff (rst)
    loadIn |=> (product == '0) && (mplierNow == $past(bIn)) && !phaseNow);

  p_add_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!loadIn && !phaseNow && mplierNow[0]) |=> product == $past(product) + $past(mcandNow));

  p_shift_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!loadIn && phaseNow) |=> $stable(product) && (mplierNow == ($past(mplierNow) >> 1)));

  p_alternate_r5: assert property (@(posedge clk) disable iff (rst)
    !loadIn |=> phaseNow != $past(phaseNow));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !loadIn) |=> done && $stable(product));

  p_done_match_r6: assert property (@(posedge clk) disable iff (rst)
    done == (mplierNow == '0));
endmodule

bind shadd_mul shadd_mul_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .loadIn(loadIn), .aIn(aIn), .bIn(bIn),
  .product(product), .done(done), .phaseNow(phaseNow),
  .mcandNow(mcandNow), .mplierNow(mplierNow)
);

// File: tb/shadd_mul_tb.sv
module shadd_mul_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadIn = 1'b0;
  logic [15:0] aIn = '0;
  logic [15:0] bIn = '0;
  logic [31:0] product;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadd_mul u_dut (
    .clk(clk), .rst(rst), .loadIn(loadIn), .aIn(aIn), .bIn(bIn),
    .product(product), .done(done)
  );

  function automatic logic [31:0] refProd(input logic [15:0] a, input logic [15:0] b);
    longint unsigned r;
    r = longint'(a) * longint'(b);
    return r[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // load captured on the next rising edge; returns at the following negedge
  task automatic loadOps(input logic [15:0] a, input logic [15:0] b);
    loadIn = 1'b1; aIn = a; bIn = b;
    @(negedge clk);
    loadIn = 1'b0;
  endtask

  task automatic runOne(input logic [15:0] a, input logic [15:0] b);
    int cyc;
    logic [31:0] settled;
    loadOps(a, b);
    check(product == 0, "R2", product, 0);
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc <= 32, "R9", cyc, 32);
    check(product == refProd(a, b), "R7", product, refProd(a, b));
    settled = product;
    repeat (5) @(negedge clk);
    check(done && product == settled, "R6", product, settled);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(product == 0, "R1", product, 0);
    check(done == 1'b1, "R1", done, 1);

    // R3 / R4 / R5 directed: a=5 b=1
    loadOps(16'd5, 16'd1);
    check(done == 1'b0, "R2", done, 0);
    @(negedge clk);
    check(product == 5, "R3", product, 5);
    check(done == 1'b0, "R5", done, 0);
    @(negedge clk);
    check(product == 5, "R4", product, 5);
    check(done == 1'b1, "R4", done, 1);

    // R3 zero-bit add keeps product: b=2
    loadOps(16'd7, 16'd2);
    @(negedge clk);
    check(product == 0, "R3", product, 0);
    @(negedge clk);
    @(negedge clk);
    check(product == 14, "R5", product, 14);

    // R7 corners
    runOne(16'h0000, 16'h1234);
    runOne(16'h1234, 16'h0000);
    runOne(16'h0001, 16'hFFFF);
    runOne(16'hFFFF, 16'h0001);
    runOne(16'hFFFF, 16'hFFFF);
    runOne(16'h8000, 16'h8000);

    // R8 load collides with a shift cycle
    loadOps(16'hABCD, 16'hFFFF);
    @(negedge clk);               // add edge done; next edge is shift
    loadOps(16'd300, 16'd21);     // captured on the shift edge
    check(product == 0, "R8", product, 0);
    repeat (40) @(negedge clk);
    check(product == refProd(16'd300, 16'd21), "R8", product, refProd(16'd300, 16'd21));

    // R8 load collides with an add cycle
    loadOps(16'h1111, 16'hF0F0);
    @(negedge clk);
    @(negedge clk);               // next edge is add
    loadOps(16'd9, 16'd9);
    check(product == 0, "R8", product, 0);
    repeat (40) @(negedge clk);
    check(product == 81, "R8", product, 81);

    // random operands
    for (int i = 0; i < 40; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      runOne(ra, rb);
    end

    // R1 reset mid-operation
    loadOps(16'h00FF, 16'h00FF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(product == 0 && done == 1'b1, "R1", {product, 1'b0} | done, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule